// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Serial DAC Input Port

This block is the digital front end of a two-channel 14-bit voltage-output converter. Each channel has its own serial port and its own load strobe. The serial port has an active-low frame signal, a serial clock and a data line. A 16-bit word shifts into the channel's staging register. A second register, the output code register, holds the code that drives the converter. The load strobe moves the staged word into that output register. It does so either immediately, when no frame is open, or at the moment the last bit of a frame arrives, when the strobe is held low across that moment.

The block runs on a system clock at least four times faster than the serial clock. Every serial input passes through a synchronizer, and the block finds the edges of the synchronized signals itself. Each channel presents its output code register as a two's-complement word. A one-cycle update pulse marks every change of that register.

Top module: `dual_serial_dac_port`

## Requirements
- R1: After reset, both staging registers and both output code registers hold 0x0000 (midscale), and no update pulse is raised.
- R2: A falling edge of the frame input opens a frame. Bits are captured on falling edges of the serial clock while the frame is open. Of the 16 bits, the first two are ignored. The remaining 14 bits form the code, most significant bit first.
- R3: Once 16 bits are captured, further serial clock falling edges in the same low period of the frame input change nothing.
- R4: If the frame input rises before the 16th bit, the partial word is dropped, and the staging register keeps its previous content.
- R5: A load strobe falling edge while no frame is open copies the staging register into the output code register. Capturing a frame alone never changes the output code register.
- R6: While the load strobe is held low, the 16th captured bit of a frame writes the new 14-bit code straight into the output code register.
- R7: A load strobe falling edge while a frame is open causes no update at that edge. If the strobe is still low at the 16th bit, the update happens then.
- R8: If the load strobe rises again before the 16th bit, that frame causes no update.
- R9: Codes pass through unchanged as two's complement: 0x1FFF (most positive), 0x2000 (most negative) and 0x3FFE are delivered exactly.
- R10: The two channels are independent. Traffic or strobes on one channel never change the other channel's outputs.
- R11: An update appears on the outputs three system clock edges after the serial clock or strobe input edge that causes it.
- R12: Each update is marked by a one-cycle pulse on that channel's update output. The output code changes only in a cycle where that pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | NCH | Per-channel active-low frame input |
| sclk | input | NCH | Per-channel serial clock; bits are taken on its falling edge |
| sdata | input | NCH | Per-channel serial data |
| load_n | input | NCH | Per-channel active-low load strobe |
| dac_code | output | NCH*14 | Output code registers; channel c occupies bits [14c+13:14c] |
| dac_update | output | NCH | One-cycle pulse per channel when its output code register is written |

## Verification
Each update is due on the third system clock edge after the input edge that triggers it. That edge is either the 16th serial clock fall or an idle strobe fall. Two synchronizer stages and the output register make up the three edges. Whenever the driver creates such an edge, it pushes the expected code stamped with the current cycle count plus three. The monitor samples on the falling clock edge and compares both the code and the cycle of every update pulse. It flags any pulse with nothing pending, any expected item whose cycle passes unmet, and any code change without a pulse. In this way, both the suppressed updates and the deferred updates are checked at the exact cycle.

// File: rtl/dacport_pkg.sv
package dacport_pkg;

    localparam int FRAME_LEN = 16;
    localparam int CODE_W    = 14;
    localparam int PAD_W     = FRAME_LEN - CODE_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);

    typedef logic [CODE_W-1:0]    code_t;
    typedef logic [CNT_W-1:0]     bitcnt_t;
    typedef logic [FRAME_LEN-1:0] frame_t;

    // raw pins of one channel
    typedef struct packed {
        logic frame_n;
        logic sclk;
        logic sdata;
        logic load_n;
    } pins_t;

    // edge/level events derived from synchronized pins
    typedef struct packed {
        logic frame_fall;
        logic frame_rise;
        logic sclk_fall;
        logic sdata;
        logic load_fall;
        logic load_low;
    } events_t;

    // word completed by the frame receiver
    typedef struct packed {
        logic  valid;
        code_t code;
    } word_t;

    // the leading pad bits are dropped, the code sits in the low bits
    function automatic code_t take_code(input frame_t f);
        return f[CODE_W-1:0];
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync
    import dacport_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  pins_t   raw,
    output events_t ev
);

    localparam int PW = $bits(pins_t);

    logic [PW-1:0] stg [STAGES];
    pins_t         cur;
    pins_t         prev;

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= raw;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign cur = pins_t'(stg[STAGES-1]);

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= cur;
    end

    always_comb begin
        ev.frame_fall = prev.frame_n & ~cur.frame_n;
        ev.frame_rise = ~prev.frame_n & cur.frame_n;
        ev.sclk_fall  = prev.sclk & ~cur.sclk;
        ev.sdata      = cur.sdata;
        ev.load_fall  = prev.load_n & ~cur.load_n;
        ev.load_low   = ~cur.load_n;
    end

endmodule

// File: rtl/frame_rx.sv
module frame_rx
    import dacport_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  events_t ev,
    output word_t   word,
    output code_t   staged,
    output logic    busy
);

    logic                 open_q;
    bitcnt_t              cnt_q;
    logic [FRAME_LEN-2:0] shreg_q;
    code_t                staged_q;
    logic                 shift;
    logic                 last;
    frame_t               full;

    assign shift = open_q && ev.sclk_fall && !ev.frame_fall;
    assign last  = shift && (cnt_q == bitcnt_t'(FRAME_LEN - 1));
    assign full  = {shreg_q, ev.sdata};

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q   <= 1'b0;
            cnt_q    <= '0;
            shreg_q  <= '0;
            staged_q <= '0;
        end else if (ev.frame_fall) begin
            open_q <= 1'b1;
            cnt_q  <= '0;
        end else if (ev.frame_rise) begin
            open_q <= 1'b0;
        end else if (shift) begin
            shreg_q <= full[FRAME_LEN-2:0];
            cnt_q   <= cnt_q + 1'b1;
            if (last) begin
                open_q   <= 1'b0;
                staged_q <= take_code(full);
            end
        end
    end

    assign word.valid = last;
    assign word.code  = take_code(full);
    assign staged     = staged_q;
    assign busy       = open_q;

    // R3: bit counter never passes the frame length
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= bitcnt_t'(FRAME_LEN));

    // R3: after the last bit the frame is closed to further clocks
    p_closed_after_last_r3: assert property (@(posedge clk) disable iff (rst)
        last |=> !busy);

    // R4: an early frame end leaves the staging register untouched
    p_abort_keeps_r4: assert property (@(posedge clk) disable iff (rst)
        (ev.frame_rise && !ev.frame_fall) |=> $stable(staged));

endmodule

// File: rtl/load_ctrl.sv
module load_ctrl
    import dacport_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  events_t ev,
    input  word_t   word,
    input  code_t   staged,
    input  logic    busy,
    output code_t   dac,
    output logic    upd
);

    code_t dac_q;
    logic  upd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_q <= '0;
            upd_q <= 1'b0;
        end else begin
            upd_q <= 1'b0;
            if (word.valid && ev.load_low) begin
                dac_q <= word.code;
                upd_q <= 1'b1;
            end else if (ev.load_fall && !busy) begin
                dac_q <= staged;
                upd_q <= 1'b1;
            end
        end
    end

    assign dac = dac_q;
    assign upd = upd_q;

    // R1: reset leaves midscale and no pulse
    p_reset_mid_r1: assert property (@(posedge clk)
        rst |=> (dac == '0 && !upd));

    // R5: idle strobe fall copies the staging register
    p_idle_copy_r5: assert property (@(posedge clk) disable iff (rst)
        (ev.load_fall && !busy && !word.valid) |=> (upd && dac == $past(staged)));

    // R6: last bit with strobe low writes the fresh code
    p_low_load_r6: assert property (@(posedge clk) disable iff (rst)
        (word.valid && ev.load_low) |=> (upd && dac == $past(word.code)));

    // R7: strobe fall inside a frame does nothing at that edge
    p_busy_fall_r7: assert property (@(posedge clk) disable iff (rst)
        (ev.load_fall && busy && !word.valid) |=> !upd);

    // R8: last bit with strobe high gives no update
    p_high_skip_r8: assert property (@(posedge clk) disable iff (rst)
        (word.valid && !ev.load_low) |=> !upd);

    // R12: code only moves together with the pulse
    p_code_with_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        !upd |-> $stable(dac));

endmodule

// File: rtl/dac_channel.sv
module dac_channel
    import dacport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t pins,
    output code_t dac,
    output logic  upd
);

    events_t ev;
    word_t   word;
    code_t   staged;
    logic    busy;

    pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .raw (pins),
        .ev  (ev)
    );

    frame_rx u_rx (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .word   (word),
        .staged (staged),
        .busy   (busy)
    );

    load_ctrl u_load (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .word   (word),
        .staged (staged),
        .busy   (busy),
        .dac    (dac),
        .upd    (upd)
    );

endmodule

// File: rtl/dual_serial_dac_port.sv
module dual_serial_dac_port
    import dacport_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH-1:0]        frame_n,
    input  logic [NCH-1:0]        sclk,
    input  logic [NCH-1:0]        sdata,
    input  logic [NCH-1:0]        load_n,
    output logic [NCH*CODE_W-1:0] dac_code,
    output logic [NCH-1:0]        dac_update
);

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            pins_t pins;
            code_t code;

            assign pins.frame_n = frame_n[c];
            assign pins.sclk    = sclk[c];
            assign pins.sdata   = sdata[c];
            assign pins.load_n  = load_n[c];

            dac_channel #(.SYNC_STAGES(SYNC_STAGES)) u_ch (
                .clk  (clk),
                .rst  (rst),
                .pins (pins),
                .dac  (code),
                .upd  (dac_update[c])
            );

            assign dac_code[c*CODE_W +: CODE_W] = code;
        end
    endgenerate

endmodule

// File: tb/sim_dual_serial_dac_port.sv
module sim_dual_serial_dac_port;
    localparam int CLK_PERIOD = 10;
    localparam int HB         = 4;
    localparam int LAT        = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  frame_n = 2'b11;
    logic [1:0]  sclk = 2'b00;
    logic [1:0]  sdata = 2'b00;
    logic [1:0]  load_n = 2'b11;
    logic [27:0] dac_code;
    logic [1:0]  dac_update;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    logic [13:0] inl [2];
    logic [13:0] prev_code [2];

    int          due0[$];
    int          due1[$];
    logic [13:0] code0[$];
    logic [13:0] code1[$];
    string       tag0[$];
    string       tag1[$];

    dual_serial_dac_port u0 (
        .clk        (clk),
        .rst        (rst),
        .frame_n    (frame_n),
        .sclk       (sclk),
        .sdata      (sdata),
        .load_n     (load_n),
        .dac_code   (dac_code),
        .dac_update (dac_update)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input int ch, input logic [13:0] code, input string tag);
        if (ch == 0) begin due0.push_back(cyc + LAT); code0.push_back(code); tag0.push_back(tag); end
        else         begin due1.push_back(cyc + LAT); code1.push_back(code); tag1.push_back(tag); end
    endtask

    task automatic strobe(input int ch, input string tag);
        load_n[ch] = 1'b0;
        push(ch, inl[ch], tag);
        tick(6);
        load_n[ch] = 1'b1;
        tick(6);
    endtask

    // R2, R3, R4, R6, R7, R8: one frame, strobe optionally toggled at given bits
    task automatic send(input int ch, input logic [15:0] w, input int nbits,
                        input int fall_at, input int rise_at, input string tag);
        frame_n[ch] = 1'b0;
        tick(HB);
        for (int i = 0; i < nbits; i++) begin
            if (i == fall_at) load_n[ch] = 1'b0;
            if (i == rise_at) load_n[ch] = 1'b1;
            sdata[ch] = (i < 16) ? w[15-i] : i[0];
            sclk[ch]  = 1'b1;
            tick(HB);
            sclk[ch]  = 1'b0;
            if (i == 15) begin
                inl[ch] = w[13:0];
                if (load_n[ch] == 1'b0) push(ch, w[13:0], tag);
            end
            tick(HB);
        end
        frame_n[ch] = 1'b1;
        tick(HB);
        if (fall_at >= 0 && load_n[ch] == 1'b0) begin
            load_n[ch] = 1'b1;
            tick(HB);
        end
    endtask

    task automatic check_code(input int ch, input logic [13:0] exp, input string tag);
        checks++;
        if (dac_code[ch*14 +: 14] !== exp) begin
            errors++;
            $display("FAIL %s ch%0d code: actual %h expected %h", tag, ch, dac_code[ch*14 +: 14], exp);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // scoreboard monitor: R11 timing, R12 pulse/code coupling
    always @(negedge clk) begin
        if (!rst) begin
            for (int ch = 0; ch < 2; ch++) begin
                logic [13:0] now;
                now = dac_code[ch*14 +: 14];
                if (dac_update[ch]) begin
                    int dd;
                    logic [13:0] cc;
                    string tt;
                    checks++;
                    if ((ch == 0 && due0.size() == 0) || (ch == 1 && due1.size() == 0)) begin
                        errors++;
                        $display("FAIL R10 ch%0d unexpected update: actual %h expected none", ch, now);
                    end else begin
                        if (ch == 0) begin dd = due0.pop_front(); cc = code0.pop_front(); tt = tag0.pop_front(); end
                        else         begin dd = due1.pop_front(); cc = code1.pop_front(); tt = tag1.pop_front(); end
                        if (now !== cc) begin
                            errors++;
                            $display("FAIL %s ch%0d code: actual %h expected %h", tt, ch, now, cc);
                        end
                        if (cyc != dd) begin
                            errors++;
                            $display("FAIL R11 (%s) ch%0d update cycle: actual %0d expected %0d", tt, ch, cyc, dd);
                        end
                    end
                end else begin
                    if (now !== prev_code[ch]) begin
                        errors++;
                        $display("FAIL R12 ch%0d code moved without pulse: actual %h expected %h", ch, now, prev_code[ch]);
                    end
                    if (ch == 0 && due0.size() > 0 && due0[0] < cyc) begin
                        errors++;
                        $display("FAIL %s ch0 missing update: actual none expected %h", tag0[0], code0[0]);
                        void'(due0.pop_front()); void'(code0.pop_front()); void'(tag0.pop_front());
                    end
                    if (ch == 1 && due1.size() > 0 && due1[0] < cyc) begin
                        errors++;
                        $display("FAIL %s ch1 missing update: actual none expected %h", tag1[0], code1[0]);
                        void'(due1.pop_front()); void'(code1.pop_front()); void'(tag1.pop_front());
                    end
                end
                prev_code[ch] = now;
            end
        end else begin
            prev_code[0] = dac_code[13:0];
            prev_code[1] = dac_code[27:14];
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        inl[0] = '0;
        inl[1] = '0;
        tick(5);
        rst = 1'b0;
        tick(3);
        // R1: midscale and quiet after reset
        check_code(0, 14'h0000, "R1");
        check_code(1, 14'h0000, "R1");
        checks++;
        if (dac_update !== 2'b00) begin
            errors++;
            $display("FAIL R1 update after reset: actual %b expected 00", dac_update);
        end

        // R2: pad bits set, ignored; R5: frame alone leaves output
        send(0, 16'hC123, 16, -1, -1, "R2");
        tick(4);
        check_code(0, 14'h0000, "R5");
        strobe(0, "R2");

        // R9: extreme codes
        send(0, 16'h1FFF, 16, -1, -1, "R9");
        strobe(0, "R9");
        send(0, 16'h2000, 16, -1, -1, "R9");
        strobe(0, "R9");

        // R4: partial frame dropped
        send(0, 16'h0555, 9, -1, -1, "R4");
        strobe(0, "R4");
        check_code(0, 14'h2000, "R4");

        // R3: extra clocks ignored
        send(0, 16'h3A5A, 21, -1, -1, "R3");
        strobe(0, "R3");
        check_code(0, 14'h3A5A, "R3");

        // R6: strobe held low across frames on channel 1
        load_n[1] = 1'b0;
        push(1, inl[1], "R5");
        tick(6);
        send(1, 16'h0777, 16, -1, -1, "R6");
        send(1, 16'h1234, 16, -1, -1, "R6");
        load_n[1] = 1'b1;
        tick(6);
        check_code(0, 14'h3A5A, "R10");

        // R7: strobe falls mid-frame and stays low
        send(0, 16'h0ABC, 16, 4, -1, "R7");

        // R8: strobe falls then rises mid-frame
        send(0, 16'h0F0F, 16, 3, 10, "R8");
        check_code(0, 14'h0ABC, "R8");
        strobe(0, "R8");

        // R10: simultaneous traffic, only one strobed
        fork
            send(0, 16'h0011, 16, -1, -1, "R10");
            send(1, 16'h3FFE, 16, -1, -1, "R10");
        join
        strobe(1, "R9");
        check_code(0, 14'h0F0F, "R10");
        strobe(0, "R10");

        tick(10);
        checks++;
        if (due0.size() != 0 || due1.size() != 0) begin
            errors++;
            $display("FAIL R11 pending updates: actual %0d expected 0", due0.size() + due1.size());
        end
        summary();
    end

endmodule